// File: doc/BRIEF.md
# Eight-Operation Bitwise Function Unit

This is a purely combinational logic unit. It takes two operands of equal width and a 3-bit operation code, and it returns a result of the same width. Every bit of the result is produced by a separate slice. A slice sees only its own bit of each operand and applies one of eight two-input logic functions to them. Two of the eight functions are constants: all ones and all zeros.

Each slice works as a multiplexer with eight inputs. Every one of the eight functions is evaluated on the slice's operand pair, and the operation code selects one of them. All slices share the same select lines. The code map is arranged so that a code and its bitwise complement always select complementary functions. This lets a caller invert any result by inverting the code. Nothing is registered, and the block has no arithmetic, carry or flags.

Top module: `bitop_unit`

## Requirements
- R1: With op_i = 3'b000, every bit of f_o is 1 whatever the operands.
- R2: With op_i = 3'b001, f_o equals a_i | b_i.
- R3: With op_i = 3'b010, f_o equals ~(a_i & b_i).
- R4: With op_i = 3'b011, f_o equals a_i ^ b_i.
- R5: With op_i = 3'b100, f_o equals ~(a_i ^ b_i).
- R6: With op_i = 3'b101, f_o equals a_i & b_i.
- R7: With op_i = 3'b110, f_o equals ~(a_i | b_i).
- R8: With op_i = 3'b111, every bit of f_o is 0 whatever the operands.
- R9: For every code c and every pair of operands, f_o under code c equals the bitwise NOT of f_o under code ~c.
- R10: For any WIDTH, bit i of f_o depends only on bit i of a_i and bit i of b_i. op_i[2] is the most significant select bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code; bit 2 is the most significant select bit |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| f_o | output | WIDTH | Result, computed bit by bit |

## Verification
The bench uses two copies of the unit at the default WIDTH of 4. Between them, all eight codes meet all 256 operand pairs. The second copy always receives the complemented code, so R9 is compared pair by pair across the whole operand space. A third copy is built with WIDTH 9. Walking-one and alternating operand patterns on it show that a bit changed in one slice does not reach its neighbours, and that slices above the narrow default behave the same as the lower ones.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int unsigned OP_W  = 3;
  localparam int unsigned N_OPS = 1 << OP_W;
  localparam int unsigned TT_W  = 4;  // truth table indexed by {a,b}

  typedef enum logic [OP_W-1:0] {
    OP_ONE  = 3'b000,
    OP_OR   = 3'b001,
    OP_NAND = 3'b010,
    OP_XOR  = 3'b011,
    OP_XNOR = 3'b100,
    OP_AND  = 3'b101,
    OP_NOR  = 3'b110,
    OP_ZERO = 3'b111
  } op_e;

  // Only codes with msb=0 are stored; the upper half is the complement of the mirror code.
  function automatic logic [TT_W-1:0] base_table(input logic [OP_W-2:0] code);
    case (code)
      2'b00:   base_table = 4'b1111;  // one
      2'b01:   base_table = 4'b1110;  // or
      2'b10:   base_table = 4'b0111;  // nand
      default: base_table = 4'b0110;  // xor
    endcase
  endfunction

  function automatic logic [TT_W-1:0] op_table(input logic [OP_W-1:0] code);
    logic [OP_W-1:0] mirror;
    mirror = ~code;
    if (code[OP_W-1]) op_table = ~base_table(mirror[OP_W-2:0]);
    else              op_table = base_table(code[OP_W-2:0]);
  endfunction
endpackage

// File: rtl/bitop_mux8.sv
module bitop_mux8
  import bitop_pkg::*;
(
  input  logic [N_OPS-1:0] d_i,
  input  logic [OP_W-1:0]  sel_i,
  output logic             y_o
);
  localparam int unsigned L1 = N_OPS / 2;
  localparam int unsigned L2 = N_OPS / 4;

  logic [L1-1:0] s0;
  logic [L2-1:0] s1;

  // lsb picks first, msb last
  for (genvar k = 0; k < L1; k++) begin : g_s0
    assign s0[k] = sel_i[0] ? d_i[2*k+1] : d_i[2*k];
  end
  for (genvar k = 0; k < L2; k++) begin : g_s1
    assign s1[k] = sel_i[1] ? s0[2*k+1] : s0[2*k];
  end
  assign y_o = sel_i[2] ? s1[1] : s1[0];
endmodule

// File: rtl/bitop_slice.sv
module bitop_slice
  import bitop_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            a_i,
  input  logic            b_i,
  output logic            f_o
);
  logic [N_OPS-1:0] cand;
  logic [1:0]       idx;

  assign idx = {a_i, b_i};

  for (genvar c = 0; c < N_OPS; c++) begin : g_cand
    localparam logic [TT_W-1:0] TT = op_table(OP_W'(c));
    assign cand[c] = TT[idx];
  end

  bitop_mux8 u_mux (
    .d_i  (cand),
    .sel_i(op_i),
    .y_o  (f_o)
  );
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] f_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    bitop_slice u_slice (
      .op_i(op_i),
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .f_o (f_o[i])
    );
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
  import bitop_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] f_o
);
  always_comb begin
    case (op_i)
      3'b000: assert_all_one_R1: assert (f_o == {WIDTH{1'b1}}) else $error("R1");
      3'b001: assert_or_R2:      assert (f_o == (a_i | b_i))    else $error("R2");
      3'b010: assert_nand_R3:    assert (f_o == ~(a_i & b_i))   else $error("R3");
      3'b011: assert_xor_R4:     assert (f_o == (a_i ^ b_i))    else $error("R4");
      3'b100: assert_xnor_R5:    assert (f_o == ~(a_i ^ b_i))   else $error("R5");
      3'b101: assert_and_R6:     assert (f_o == (a_i & b_i))    else $error("R6");
      3'b110: assert_nor_R7:     assert (f_o == ~(a_i | b_i))   else $error("R7");
      default: assert_all_zero_R8: assert (f_o == '0)          else $error("R8");
    endcase
  end
endmodule

bind bitop_unit bitop_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .op_i(op_i),
  .a_i (a_i),
  .b_i (b_i),
  .f_o (f_o)
);

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
  localparam time CLK_P  = 10ns;
  localparam int  NW     = 4;
  localparam int  WW     = 9;
  localparam int  WD_MAX = 50000;

  typedef struct {
    logic [2:0]    op;
    logic [WW-1:0] exp;
    bit            wide;
    int            req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [2:0]    op_n, op_c, op_w;
  logic [NW-1:0] a_n, b_n, f_n, f_c;
  logic [WW-1:0] a_w, b_w, f_w;

  assign op_c = ~op_n;

  bitop_unit #(.WIDTH(NW)) u0 (.op_i(op_n), .a_i(a_n), .b_i(b_n), .f_o(f_n));
  bitop_unit #(.WIDTH(NW)) u1 (.op_i(op_c), .a_i(a_n), .b_i(b_n), .f_o(f_c));
  bitop_unit #(.WIDTH(WW)) u2 (.op_i(op_w), .a_i(a_w), .b_i(b_w), .f_o(f_w));

  item_t q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  function automatic logic [WW-1:0] model(input logic [2:0] op,
                                         input logic [WW-1:0] a,
                                         input logic [WW-1:0] b);
    case (op)
      3'd0: model = '1;          // R1
      3'd1: model = a | b;       // R2
      3'd2: model = ~(a & b);    // R3
      3'd3: model = a ^ b;       // R4
      3'd4: model = ~(a ^ b);    // R5
      3'd5: model = a & b;       // R6
      3'd6: model = ~(a | b);    // R7
      default: model = '0;       // R8
    endcase
  endfunction

  task automatic drive_n(input logic [2:0] op, input logic [NW-1:0] a, input logic [NW-1:0] b);
    item_t it;
    @(posedge clk);
    op_n = op; a_n = a; b_n = b;
    it.op = op; it.wide = 1'b0; it.req = int'(op) + 1;
    it.exp = WW'(NW'(model(op, WW'(a), WW'(b))));
    q.push_back(it);
  endtask

  task automatic drive_w(input logic [2:0] op, input logic [WW-1:0] a, input logic [WW-1:0] b);
    item_t it;
    @(posedge clk);
    op_w = op; a_w = a; b_w = b;
    it.op = op; it.wide = 1'b1; it.req = 10;
    it.exp = model(op, a, b);
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.wide) begin
        total++;
        if (f_w !== it.exp) begin
          bad++;
          $display("FAIL R10 op=%b act=%b exp=%b", it.op, f_w, it.exp);
        end
      end else begin
        total++;
        if (f_n !== it.exp[NW-1:0]) begin
          bad++;
          $display("FAIL R%0d op=%b act=%b exp=%b", it.req, it.op, f_n, it.exp[NW-1:0]);
        end
        total++;  // R9: complement code gives complement result
        if (f_n !== ~f_c) begin
          bad++;
          $display("FAIL R9 op=%b act=%b exp=%b", it.op, f_n, ~f_c);
        end
      end
    end
  end

  initial begin
    op_n = '0; a_n = '0; b_n = '0;
    op_w = '0; a_w = '0; b_w = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1..R8 and R9: every code against every narrow operand pair
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive_n(3'(c), NW'(a), NW'(b));
    // R10: walking one on each operand, wide instance
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < WW; i++) begin
        drive_w(3'(c), WW'(1) << i, '0);
        drive_w(3'(c), '0, WW'(1) << i);
        drive_w(3'(c), ~(WW'(1) << i), '1);
      end
      drive_w(3'(c), 9'h155, 9'h0AA);
      drive_w(3'(c), 9'h155, 9'h155);
      drive_w(3'(c), 9'h1F0, 9'h0FF);
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WD_MAX) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<%0d cycles", cyc, WD_MAX);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule